// File: doc/BRIEF.md
# Configuration Target Status Poll Engine

This block repeatedly reads the status byte of a configuration target attached over SPI until a caller-specified condition is met. A caller raises a one-cycle request with an 8-bit mask. The engine then takes status samples one after another with no delay between them. For each sample it runs two identical one-byte read transfers, releasing chip-select between the two, and keeps only the byte returned by the second transfer. The first byte after chip-select falls is not reliable, so it is discarded.

Each kept byte is examined in priority order. Bit 2 or bit 3 set is a target-side fault, and the poll ends at once with an I/O error. Otherwise, the poll succeeds when the busy flag (bit 0) is clear and every bit of the mask is set. Otherwise, if the overall time budget has run out, the poll ends with a timeout. In every other case a new sample starts immediately. The time budget is a cycle count derived from the clock frequency and a timeout in milliseconds. It restarts with every accepted request.

The byte transfers are made by a separate mode-0 shifter. It drives SCK low while idle, sends data MSB first, samples MISO on the rising SCK edge, and holds chip-select high for a fixed number of cycles after each byte.

Top module: `stat_poll_engine`

## Requirements
- R1: After reset, chip-select is high, SCK is low, `poll_busy` is low and `poll_done` is low.
- R2: Each status sample is exactly two chip-select-low transfers of 8 SCK pulses each. Each transfer shifts out the read opcode 0x00 MSB first. SCK is low whenever chip-select is high.
- R3: The byte returned in the first transfer of a sample is discarded. Fault bits set in that byte do not affect the outcome.
- R4: If bit 2 or bit 3 of a kept byte is set, the poll ends with result code 1 (I/O error) and `poll_status` equal to that byte. No further transfers follow.
- R5: If a kept byte has bit 0 clear and all mask bits set, the poll ends with result code 0 and `poll_status` equal to that byte.
- R6: With a zero mask, a kept byte with bits 0, 2 and 3 clear is enough for success.
- R7: A sample that neither faults nor succeeds, taken before the time budget runs out, is followed by a new sample at once. The number of transfers in a poll is twice the number of samples it evaluated.
- R8: When a sample is evaluated after CLK_FREQ_HZ*TIMEOUT_MS/1000 cycles have passed since the request was accepted, and that sample neither faults nor succeeds, the poll ends with result code 2 (timeout).
- R9: `poll_done` is a one-cycle pulse. `poll_busy` is high from the cycle after acceptance until the done cycle, and low in the done cycle.
- R10: A request raised while `poll_busy` is high is ignored. The running poll keeps its mask and its outcome, and no second poll starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| poll_req | input | 1 | Start a poll; honoured only while idle |
| poll_mask | input | 8 | Status bits that must all be set for success |
| poll_busy | output | 1 | Poll in progress |
| poll_done | output | 1 | One-cycle completion pulse |
| poll_result | output | 2 | 0 success, 1 I/O error, 2 timeout; valid with `poll_done` |
| poll_status | output | 8 | Last kept status byte; valid with `poll_done` |
| spi_cs_n | output | 1 | Active-low chip-select |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to target |
| spi_miso | input | 1 | Serial data from target |

## Verification
If the engine kept the first byte of a pair, the bench would see it immediately: every first byte carries both fault bits, so the first sample would end with code 1. If the evaluator ordered its checks wrongly, or applied the mask wrongly, the wrong result code or status byte would appear on the `poll_done` of the first affected sample. A wrong sample sequence or a stuck timer shows up as a wrong count of chip-select cycles per poll, or as done arriving outside the expected window.

// File: rtl/stat_poll_pkg.sv
package stat_poll_pkg;
  localparam int STAT_W = 8;
  localparam logic [STAT_W-1:0] OP_READ_STATUS = 8'h00;
  localparam int BIT_BUSY  = 0;
  localparam int BIT_READY = 1;
  localparam int BIT_VIOL  = 2;
  localparam int BIT_FAULT = 3;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_IO_ERR  = 2'd1,
    RES_TIMEOUT = 2'd2
  } poll_res_e;

  typedef enum logic [1:0] {
    PS_IDLE,
    PS_FIRST,
    PS_SECOND,
    PS_EVAL
  } poll_state_e;
endpackage

// File: rtl/spi_byte_xfer.sv
module spi_byte_xfer #(
  parameter int W        = 8,
  parameter int SCK_HALF = 2,
  parameter int CS_HIGH  = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] tx_byte,
  output logic         done,
  output logic [W-1:0] rx_byte,
  output logic         spi_cs_n,
  output logic         spi_sck,
  output logic         spi_mosi,
  input  logic         spi_miso
);
  localparam int BW = (W > 1) ? $clog2(W) : 1;
  localparam int DW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam int GW = (CS_HIGH > 1) ? $clog2(CS_HIGH) : 1;

  typedef enum logic [1:0] {X_IDLE, X_SHIFT, X_GAP} xst_e;
  xst_e          st;
  logic [W-1:0]  tx_sr, rx_sr;
  logic [BW-1:0] bit_cnt;
  logic [DW-1:0] div_cnt;
  logic [GW-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= X_IDLE;
      spi_cs_n <= 1'b1;
      spi_sck  <= 1'b0;
      spi_mosi <= 1'b0;
      tx_sr    <= '0;
      rx_sr    <= '0;
      rx_byte  <= '0;
      bit_cnt  <= '0;
      div_cnt  <= '0;
      gap_cnt  <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        X_IDLE: begin
          if (start) begin
            spi_cs_n <= 1'b0;
            tx_sr    <= tx_byte;
            spi_mosi <= tx_byte[W-1];
            bit_cnt  <= '0;
            div_cnt  <= '0;
            st       <= X_SHIFT;
          end
        end
        X_SHIFT: begin
          if (div_cnt == DW'(SCK_HALF - 1)) begin
            div_cnt <= '0;
            if (!spi_sck) begin
              spi_sck <= 1'b1;
              rx_sr   <= {rx_sr[W-2:0], spi_miso};
            end else begin
              spi_sck <= 1'b0;
              if (bit_cnt == BW'(W - 1)) begin
                spi_cs_n <= 1'b1;
                gap_cnt  <= '0;
                st       <= X_GAP;
              end else begin
                bit_cnt  <= bit_cnt + 1'b1;
                tx_sr    <= {tx_sr[W-2:0], 1'b0};
                spi_mosi <= tx_sr[W-2];
              end
            end
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        X_GAP: begin
          if (gap_cnt == GW'(CS_HIGH - 1)) begin
            done    <= 1'b1;
            rx_byte <= rx_sr;
            st      <= X_IDLE;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        default: st <= X_IDLE;
      endcase
    end
  end

  // R2: SCK is idle low whenever chip-select is released
  assert_sck_idle_R2: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck);
  // R2: chip-select stays released for the gap after every byte
  assert_cs_gap_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_cs_n) |=> spi_cs_n);
endmodule

// File: rtl/poll_timeout_ctr.sv
module poll_timeout_ctr #(
  parameter longint LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (clr) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (run && !expired) begin
      cnt <= cnt + 1'b1;
      if (cnt == CW'(LIMIT - 1)) expired <= 1'b1;
    end
  end

  // R8: once expired the flag holds until the next request clears it
  assert_expired_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (expired && !clr) |=> expired);
endmodule

// File: rtl/poll_status_eval.sv
module poll_status_eval
  import stat_poll_pkg::*;
(
  input  logic [STAT_W-1:0] status,
  input  logic [STAT_W-1:0] mask,
  output logic              fault,
  output logic              met
);
  logic [STAT_W-1:0] busy_bit;
  always_comb begin
    busy_bit           = '0;
    busy_bit[BIT_BUSY] = 1'b1;
    fault = status[BIT_VIOL] | status[BIT_FAULT];
    met   = ((status & (busy_bit | mask)) == mask);
  end
endmodule

// File: rtl/stat_poll_engine.sv
module stat_poll_engine
  import stat_poll_pkg::*;
#(
  parameter longint CLK_FREQ_HZ = 100_000_000,
  parameter int     TIMEOUT_MS  = 2000,
  parameter int     SCK_HALF    = 2,
  parameter int     CS_HIGH     = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        poll_req,
  input  logic [7:0]  poll_mask,
  output logic        poll_busy,
  output logic        poll_done,
  output logic [1:0]  poll_result,
  output logic [7:0]  poll_status,
  output logic        spi_cs_n,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam longint TO_CYCLES = (CLK_FREQ_HZ * TIMEOUT_MS) / 1000;

  poll_state_e       st;
  logic [STAT_W-1:0] mask_q, sample_q, rx_byte;
  logic              xfer_start, xfer_done, accept;
  logic              fault, met, expired;

  assign accept = (st == PS_IDLE) && poll_req;

  spi_byte_xfer #(.W(STAT_W), .SCK_HALF(SCK_HALF), .CS_HIGH(CS_HIGH)) u_xfer (
    .clk(clk), .rst(rst), .start(xfer_start), .tx_byte(OP_READ_STATUS),
    .done(xfer_done), .rx_byte(rx_byte), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  poll_timeout_ctr #(.LIMIT(TO_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .clr(accept), .run(poll_busy), .expired(expired)
  );

  poll_status_eval u_eval (
    .status(sample_q), .mask(mask_q), .fault(fault), .met(met)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= PS_IDLE;
      mask_q      <= '0;
      sample_q    <= '0;
      xfer_start  <= 1'b0;
      poll_busy   <= 1'b0;
      poll_done   <= 1'b0;
      poll_result <= RES_OK;
      poll_status <= '0;
    end else begin
      poll_done  <= 1'b0;
      xfer_start <= 1'b0;
      case (st)
        PS_IDLE: begin
          if (poll_req) begin
            mask_q     <= poll_mask;
            poll_busy  <= 1'b1;
            xfer_start <= 1'b1;
            st         <= PS_FIRST;
          end
        end
        PS_FIRST: begin
          if (xfer_done) begin
            xfer_start <= 1'b1;
            st         <= PS_SECOND;
          end
        end
        PS_SECOND: begin
          if (xfer_done) begin
            sample_q <= rx_byte;
            st       <= PS_EVAL;
          end
        end
        PS_EVAL: begin
          if (fault || met || expired) begin
            poll_busy   <= 1'b0;
            poll_done   <= 1'b1;
            poll_status <= sample_q;
            poll_result <= fault ? RES_IO_ERR : (met ? RES_OK : RES_TIMEOUT);
            st          <= PS_IDLE;
          end else begin
            xfer_start <= 1'b1;
            st         <= PS_FIRST;
          end
        end
        default: st <= PS_IDLE;
      endcase
    end
  end

  // R9: done lasts one cycle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    poll_done |=> !poll_done);
  // R9: done closes a busy interval
  assert_done_ends_busy_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(poll_done) |-> (!poll_busy && $past(poll_busy)));
  // R10: the mask of a running poll is not replaced
  assert_mask_kept_R10: assert property (@(posedge clk) disable iff (rst)
    poll_busy |=> $stable(mask_q));
  // R5: a success result always carries a byte meeting the mask with busy clear
  assert_ok_meets_mask_R5: assert property (@(posedge clk) disable iff (rst)
    (poll_done && poll_result == RES_OK) |->
      (!poll_status[BIT_BUSY] && ((poll_status & mask_q) == mask_q)));
  // R4: an I/O error result always carries a fault bit
  assert_ioerr_has_fault_R4: assert property (@(posedge clk) disable iff (rst)
    (poll_done && poll_result == RES_IO_ERR) |->
      (poll_status[BIT_VIOL] || poll_status[BIT_FAULT]));
endmodule

// File: tb/stat_poll_engine_tb.sv
module stat_poll_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam longint FREQ = 1_000_000;
  localparam int TMS = 2;
  localparam int TO_CYC = 2000;
  localparam int FIRST_BYTE = 8'h0C;

  logic clk = 0, rst = 1;
  logic poll_req = 0;
  logic [7:0] poll_mask = 0;
  logic poll_busy, poll_done;
  logic [1:0] poll_result;
  logic [7:0] poll_status;
  logic spi_cs_n, spi_sck, spi_mosi;
  logic spi_miso = 0;

  int checks = 0, fails = 0;
  logic [7:0] script [0:127];
  int xfer_idx = 0;
  logic [7:0] mdl_sr = 0, mosi_sr = 0;
  int mosi_bad = 0, sck_pulses = 0, bad_len = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stat_poll_engine #(.CLK_FREQ_HZ(FREQ), .TIMEOUT_MS(TMS), .SCK_HALF(2), .CS_HIGH(2)) dut_i (
    .clk(clk), .rst(rst), .poll_req(poll_req), .poll_mask(poll_mask),
    .poll_busy(poll_busy), .poll_done(poll_done), .poll_result(poll_result),
    .poll_status(poll_status), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // Target model: first byte of a pair is garbage with fault bits, second from script
  always @(negedge spi_cs_n) begin
    logic [7:0] b;
    b = (xfer_idx % 2 == 0) ? 8'(FIRST_BYTE) : script[(xfer_idx / 2) > 127 ? 127 : xfer_idx / 2];
    mdl_sr = b;
    spi_miso = b[7];
    sck_pulses = 0;
  end
  always @(negedge spi_sck) if (!spi_cs_n) begin
    mdl_sr = {mdl_sr[6:0], 1'b0};
    spi_miso = mdl_sr[7];
  end
  always @(posedge spi_sck) begin
    mosi_sr = {mosi_sr[6:0], spi_mosi};
    sck_pulses++;
  end
  always @(posedge spi_cs_n) if (!rst) begin
    if (mosi_sr != 8'h00) mosi_bad++;
    if (sck_pulses != 8) bad_len++;
    xfer_idx++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [7:0] v);
    for (int i = 0; i < 128; i++) script[i] = v;
  endtask

  // launch a poll and wait for done; returns cycles from request to done
  task automatic run_poll(input logic [7:0] m, output int cyc, output bit ok);
    xfer_idx = 0; mosi_bad = 0; bad_len = 0;
    @(negedge clk);
    poll_mask = m; poll_req = 1;
    @(negedge clk);
    poll_req = 0; poll_mask = 8'h00;
    cyc = 1; ok = 0;
    while (cyc < 6000) begin
      if (poll_done) begin ok = 1; break; end
      @(negedge clk); cyc++;
    end
    if (!ok) chk(0, "R9 done timeout", 0, 1);
  endtask

  task automatic expect_poll(input logic [7:0] m, input int res, input logic [7:0] st,
                             input int samples, input string tag);
    int cyc; bit ok;
    run_poll(m, cyc, ok);
    chk(poll_result == 2'(res), {tag, " result"}, poll_result, res);
    chk(poll_status == st, {tag, " status"}, poll_status, st);
    @(negedge clk);
    chk(!poll_done, "R9 done pulse width", poll_done, 0);
    chk(xfer_idx == 2*samples, "R7 transfer count", xfer_idx, 2*samples);
    chk(mosi_bad == 0 && bad_len == 0, "R2 opcode/length", mosi_bad + bad_len, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int cyc; bit ok;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(spi_cs_n == 1, "R1 cs_n", spi_cs_n, 1);
    chk(spi_sck == 0, "R1 sck", spi_sck, 0);
    chk(poll_busy == 0 && poll_done == 0, "R1 busy/done", {poll_busy, poll_done}, 0);

    // R6/R7: zero mask, busy twice then clear
    fill(8'h00); script[0] = 8'h01; script[1] = 8'h01;
    expect_poll(8'h00, 0, 8'h00, 3, "R6 zero mask");
    // R5: ready mask
    fill(8'h02); script[0] = 8'h00; script[1] = 8'h03;
    expect_poll(8'h02, 0, 8'h02, 3, "R5 ready mask");
    // R4: violation bit
    fill(8'h01); script[1] = 8'h04;
    expect_poll(8'h00, 1, 8'h04, 2, "R4 violation");
    // R4: error bit with ready set
    fill(8'h0A);
    expect_poll(8'h02, 1, 8'h0A, 1, "R4 error bit");
    // R3: first byte of each pair carries fault bits yet success is reported
    fill(8'h00);
    expect_poll(8'h00, 0, 8'h00, 1, "R3 first byte ignored");

    // R8: never-ready target
    fill(8'h01);
    run_poll(8'h00, cyc, ok);
    chk(poll_result == 2'd2, "R8 timeout code", poll_result, 2);
    chk(cyc >= TO_CYC && cyc <= TO_CYC + 200, "R8 timeout window", cyc, TO_CYC);
    chk(poll_status == 8'h01, "R8 last status", poll_status, 1);
    // R8: the budget restarts per request; a quick success afterwards
    fill(8'h00);
    expect_poll(8'h00, 0, 8'h00, 1, "R8 timer restart");

    // R10: request during busy is ignored
    fill(8'h00); script[0] = 8'h01; script[1] = 8'h01;
    xfer_idx = 0; mosi_bad = 0; bad_len = 0;
    @(negedge clk); poll_mask = 8'h00; poll_req = 1;
    @(negedge clk); poll_req = 0;
    repeat (20) @(negedge clk);
    poll_mask = 8'h02; poll_req = 1;
    @(negedge clk); poll_req = 0; poll_mask = 0;
    cyc = 0;
    while (!poll_done && cyc < 6000) begin @(negedge clk); cyc++; end
    chk(poll_result == 2'd0 && poll_status == 8'h00, "R10 mask kept", poll_status, 0);
    chk(xfer_idx == 6, "R10 sample count", xfer_idx, 6);
    repeat (200) @(negedge clk);
    chk(!poll_busy && xfer_idx == 6, "R10 no second poll", xfer_idx, 6);

    // Sweep: masks {0,ready} x status 0..15, follow-up sample forces I/O error
    for (int mi = 0; mi < 2; mi++) begin
      for (int s = 0; s < 16; s++) begin
        logic [7:0] m, sv;
        int er, es, en;
        m = mi ? 8'h02 : 8'h00;
        sv = 8'(s);
        fill(8'h04); script[0] = sv;
        if (sv[2] || sv[3]) begin er = 1; es = sv; en = 1; end
        else if (!sv[0] && ((sv & m) == m)) begin er = 0; es = sv; en = 1; end
        else begin er = 1; es = 8'h04; en = 2; end
        expect_poll(m, er, es, en, "R5 sweep");
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule